// File: doc/BRIEF.md
# Disk DMA Address, Count and Fault Unit

This unit keeps the working state of one disk DMA channel: a word-aligned target address, a transfer count, a direction bit and an enable bit. The CPU never places the DMA address on the data bus. It writes to a dedicated address window, and the unit takes the new address bits from the CPU address lines of that write. Line 14 chooses the half. When line 14 is high, lines 13:1 replace the upper address bits 21:9. When line 14 is low, lines 8:1 replace address bits 8:1. A 16-bit write to the count register sets the count, the direction and the enable at once. The stored count is the written value plus one.

A small sequencer steps the channel one word at a time. For each word it first presents the current address to the page map. It then either hands the word to the external data mover or stops on a fault. A fault is described in three status words: a general status code, a word holding the high address bits, and a word holding the low 16 address bits. When errors are enabled, a fault also raises a level-7 interrupt request. The request stays high until software clears the status words. The data mover, the page map itself and the disk controllers sit outside this unit.

Sequencer states and transitions:
- `S_IDLE` moves to `S_CHECK` when enable is set, the count is non-zero and no count write is in progress.
- `S_CHECK` drives `lookup_req`. From there it goes to `S_FAULT` if the map reports a fault, to `S_MOVE` if it does not, and to `S_IDLE` on a count write.
- `S_MOVE` drives `xfer_go`. On `xfer_ack` it returns to `S_IDLE`, which advances the address by 2 and lowers the count by 1. On a count write it returns to `S_IDLE` with no step.
- `S_FAULT` lasts one cycle. It records the status words, clears enable and returns to `S_IDLE`.

Top module: `dma_xfer_regs`

## Requirements
- R1: After reset the address, count, direction and enable are 0. All three status words read 0xFFFF. `irq7`, `lookup_req` and `xfer_go` are 0.
- R2: An address-window write with `awin_lines[14]`=1 sets address bits 21:9 from `awin_lines[13:1]`. Address bits 8:1 keep their value.
- R3: An address-window write with `awin_lines[14]`=0 sets address bits 8:1 from `awin_lines[8:1]`. Bits 21:9 keep their value, and lines 13:9 are ignored.
- R4: A count write stores `cnt_wdata[13:0]`+1, wrapping modulo 2^14, as the count. It takes direction from bit 14 (1 = memory is read) and enable from bit 15.
- R5: `cnt_rd` always equals the 14-bit count with bits 15 and 14 forced to 1.
- R6: With enable set and a non-zero count, each word takes three cycles: `lookup_req`, then `xfer_go` until `xfer_ack`. Each acknowledged word adds 2 to the address and subtracts 1 from the count. The channel goes quiet when the count reaches 0, and enable stays set.
- R7: A count write with bit 15 clear stops the channel. No further `lookup_req` or `xfer_go` follows, and the address and count stay as loaded.
- R8: The general status code depends on the fault:
  - A missing page gives 0xABFF.
  - A page mapped outside RAM gives 0xBAFF.
  - A protection fault gives 0xBBFF. A protection fault counts only when the direction is 0, that is, when memory is written.
  - The codes are checked in that priority order.
  - Bit 0x4000 is ORed in when the direction is 1, and bit 0x0400 is ORed in when `par_int_en` is 1.
- R9: On a fault, `bsr_hi` becomes 0x3C00 ORed with address bits 21:16, and `bsr_lo` becomes address bits 15:0.
- R10: A fault clears enable. The address and count keep the values they had at the fault.
- R11: A fault raises `irq7` only when `err_en` is 1. `irq7` then stays high until a `stat_clr` pulse, which also sets all three status words back to 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| awin_wr | input | 1 | Write strobe for the address window |
| awin_lines | input | 14 | CPU address lines 14:1 of that write |
| cnt_wr | input | 1 | Write strobe for the count register |
| cnt_wdata | input | 16 | Data written to the count register |
| err_en | input | 1 | Enables the fault interrupt request |
| par_int_en | input | 1 | Status flag ORed into the fault code |
| stat_clr | input | 1 | Resets the status words, drops `irq7` |
| map_present | input | 1 | The page map reports the page present |
| map_io | input | 1 | The page maps outside RAM |
| map_prot | input | 1 | The page is write-protected |
| xfer_ack | input | 1 | The data mover finished the word |
| dma_addr | output | 22 | Current DMA address, bit 0 always 0 |
| dma_cnt | output | 14 | Remaining word count |
| dma_dir | output | 1 | Direction, 1 = memory read |
| dma_en | output | 1 | Channel enable |
| cnt_rd | output | 16 | Count register read value |
| gen_stat | output | 16 | General status word |
| bsr_hi | output | 16 | Fault status, high address bits |
| bsr_lo | output | 16 | Fault status, low address bits |
| irq7 | output | 1 | Level-7 interrupt request |
| lookup_req | output | 1 | Address is being checked against the page map |
| xfer_go | output | 1 | Word transfer request to the data mover |

## Verification
Address loads are tested one half at a time, with junk placed on the unused lines. This shows that each half leaves the other half alone and that the ignored lines really are ignored.

Counts are exercised in four cases:
- a short run, checked after its first word and again at the end;
- a write of 0x3FFF, which wraps to zero and must start nothing;
- a run stalled in the transfer state and then disabled by a count write;
- a direction-only write, used to check the read-back forcing.

Faults are injected with several flag and mode combinations:
- all three map flags at once, to show the missing-page code wins;
- the outside-RAM flag alone, in read direction with errors disabled;
- write protection in write direction;
- write protection in read direction, which must not fault.

Together these separate the code priority, the direction and flag bits, and the interrupt gating.

// File: rtl/dmau_pkg.sv
package dmau_pkg;

    typedef enum logic [1:0] {
        FC_NONE,
        FC_ABSENT,
        FC_IORANGE,
        FC_PROTECT
    } fault_cls_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_CHECK,
        S_MOVE,
        S_FAULT
    } seq_state_t;

    localparam logic [15:0] GS_ABSENT  = 16'hABFF;
    localparam logic [15:0] GS_IORANGE = 16'hBAFF;
    localparam logic [15:0] GS_PROTECT = 16'hBBFF;
    localparam logic [15:0] GS_DIR_RD  = 16'h4000;
    localparam logic [15:0] GS_PIE     = 16'h0400;
    localparam logic [15:0] BS_DMA_TAG = 16'h3C00;
    localparam logic [15:0] STAT_CLEAR = 16'hFFFF;

endpackage

// File: rtl/dmau_addr_reg.sv
module dmau_addr_reg #(
    parameter int ADDR_W = 22,
    localparam int LINE_W = ADDR_W - 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [LINE_W:1]   lines,
    input  logic              adv,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-2:0] WORD_ONE = 1;

    logic [ADDR_W-1:0] addr_q;

    // Line LINE_W selects the half; CPU write beats an advance in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (wr) begin
            if (lines[LINE_W])
                addr_q[ADDR_W-1:9] <= lines[LINE_W-1:1];
            else
                addr_q[8:1] <= lines[8:1];
        end else if (adv) begin
            addr_q[ADDR_W-1:1] <= addr_q[ADDR_W-1:1] + WORD_ONE;
        end
    end

    assign addr = addr_q;

    assert_hi_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && lines[LINE_W]) |=> (addr[ADDR_W-1:9] == $past(lines[LINE_W-1:1]))
                                  && (addr[8:1] == $past(addr[8:1])));

    assert_lo_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !lines[LINE_W]) |=> (addr[8:1] == $past(lines[8:1]))
                                   && (addr[ADDR_W-1:9] == $past(addr[ADDR_W-1:9])));

endmodule

// File: rtl/dmau_count_reg.sv
module dmau_count_reg #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [CNT_W+1:0] wdata,
    input  logic             dec,
    input  logic             flt_kill,
    output logic [CNT_W-1:0] cnt,
    output logic             dir,
    output logic             en,
    output logic [CNT_W+1:0] rd
);
    localparam logic [CNT_W-1:0] CNT_ONE = 1;

    logic [CNT_W-1:0] cnt_q;
    logic             dir_q;
    logic             en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dir_q <= 1'b0;
            en_q  <= 1'b0;
        end else begin
            if (ld) begin
                cnt_q <= wdata[CNT_W-1:0] + CNT_ONE;
                dir_q <= wdata[CNT_W];
                en_q  <= wdata[CNT_W+1];
            end else if (dec) begin
                cnt_q <= cnt_q - CNT_ONE;
            end
            if (flt_kill)
                en_q <= 1'b0;
        end
    end

    assign cnt = cnt_q;
    assign dir = dir_q;
    assign en  = en_q;
    assign rd  = {2'b11, cnt_q};

    assert_cnt_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (cnt == $past(wdata[CNT_W-1:0]) + CNT_ONE) && (dir == $past(wdata[CNT_W])));

    assert_fault_kills_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flt_kill |=> !en);

endmodule

// File: rtl/dmau_fault_log.sv
module dmau_fault_log
    import dmau_pkg::*;
#(
    parameter int ADDR_W = 22,
    localparam int HI_W = ADDR_W - 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flt_stb,
    input  fault_cls_t        flt_cls,
    input  logic [ADDR_W-1:0] addr,
    input  logic              dir,
    input  logic              pie,
    input  logic              ee,
    input  logic              clr,
    output logic [15:0]       gstat,
    output logic [15:0]       bs_hi,
    output logic [15:0]       bs_lo,
    output logic              irq
);
    logic [15:0] code;
    logic [15:0] gs_nxt;
    logic [15:0] hi_nxt;

    always_comb begin
        unique case (flt_cls)
            FC_ABSENT:  code = GS_ABSENT;
            FC_IORANGE: code = GS_IORANGE;
            FC_PROTECT: code = GS_PROTECT;
            default:    code = STAT_CLEAR;
        endcase
        gs_nxt = code | (dir ? GS_DIR_RD : 16'h0000) | (pie ? GS_PIE : 16'h0000);
        hi_nxt = BS_DMA_TAG | {{(16-HI_W){1'b0}}, addr[ADDR_W-1:16]};
    end

    // A fault in the same cycle as a clear is kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gstat <= STAT_CLEAR;
            bs_hi <= STAT_CLEAR;
            bs_lo <= STAT_CLEAR;
            irq   <= 1'b0;
        end else if (flt_stb) begin
            gstat <= gs_nxt;
            bs_hi <= hi_nxt;
            bs_lo <= addr[15:0];
            if (ee)
                irq <= 1'b1;
        end else if (clr) begin
            gstat <= STAT_CLEAR;
            bs_hi <= STAT_CLEAR;
            bs_lo <= STAT_CLEAR;
            irq   <= 1'b0;
        end
    end

    assert_irq_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ee) && $past(flt_stb));

    assert_irq_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr) |=> irq);

    assert_bsr_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flt_stb |=> bs_lo == $past(addr[15:0]));

endmodule

// File: rtl/dmau_sequencer.sv
module dmau_sequencer
    import dmau_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       cnt_nz,
    input  logic       cnt_ld,
    input  logic       dir,
    input  logic       map_present,
    input  logic       map_io,
    input  logic       map_prot,
    input  logic       ack,
    output logic       lookup_req,
    output logic       xfer_go,
    output logic       step,
    output logic       flt_stb,
    output fault_cls_t flt_cls
);
    seq_state_t state_q, state_d;
    fault_cls_t cls_now, cls_q;

    always_comb begin
        if (!map_present)
            cls_now = FC_ABSENT;
        else if (map_io)
            cls_now = FC_IORANGE;
        else if (map_prot && !dir)
            cls_now = FC_PROTECT;
        else
            cls_now = FC_NONE;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (en && cnt_nz && !cnt_ld) state_d = S_CHECK;
            S_CHECK: begin
                if (cnt_ld)                 state_d = S_IDLE;
                else if (cls_now != FC_NONE) state_d = S_FAULT;
                else                        state_d = S_MOVE;
            end
            S_MOVE:  if (cnt_ld || ack) state_d = S_IDLE;
            S_FAULT: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cls_q   <= FC_NONE;
        end else begin
            state_q <= state_d;
            if (state_q == S_CHECK)
                cls_q <= cls_now;
        end
    end

    always_comb begin
        lookup_req = 1'b0;
        xfer_go    = 1'b0;
        step       = 1'b0;
        flt_stb    = 1'b0;
        flt_cls    = cls_q;
        unique case (state_q)
            S_IDLE:  ;
            S_CHECK: lookup_req = 1'b1;
            S_MOVE: begin
                xfer_go = 1'b1;
                step    = ack && !cnt_ld;
            end
            S_FAULT: flt_stb = 1'b1;
            default: ;
        endcase
    end

    assert_move_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_MOVE) |-> cnt_nz);

    assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !en) |=> (state_q == S_IDLE));

    assert_req_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lookup_req, xfer_go, flt_stb}));

endmodule

// File: rtl/dma_xfer_regs.sv
module dma_xfer_regs
    import dmau_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int CNT_W  = 14,
    localparam int LINE_W = ADDR_W - 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              awin_wr,
    input  logic [LINE_W:1]   awin_lines,
    input  logic              cnt_wr,
    input  logic [CNT_W+1:0]  cnt_wdata,
    input  logic              err_en,
    input  logic              par_int_en,
    input  logic              stat_clr,
    input  logic              map_present,
    input  logic              map_io,
    input  logic              map_prot,
    input  logic              xfer_ack,
    output logic [ADDR_W-1:0] dma_addr,
    output logic [CNT_W-1:0]  dma_cnt,
    output logic              dma_dir,
    output logic              dma_en,
    output logic [CNT_W+1:0]  cnt_rd,
    output logic [15:0]       gen_stat,
    output logic [15:0]       bsr_hi,
    output logic [15:0]       bsr_lo,
    output logic              irq7,
    output logic              lookup_req,
    output logic              xfer_go
);
    logic       step;
    logic       flt_stb;
    fault_cls_t flt_cls;

    dmau_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (awin_wr),
        .lines (awin_lines),
        .adv   (step),
        .addr  (dma_addr)
    );

    dmau_count_reg #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (cnt_wr),
        .wdata    (cnt_wdata),
        .dec      (step),
        .flt_kill (flt_stb),
        .cnt      (dma_cnt),
        .dir      (dma_dir),
        .en       (dma_en),
        .rd       (cnt_rd)
    );

    dmau_sequencer u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (dma_en),
        .cnt_nz      (dma_cnt != '0),
        .cnt_ld      (cnt_wr),
        .dir         (dma_dir),
        .map_present (map_present),
        .map_io      (map_io),
        .map_prot    (map_prot),
        .ack         (xfer_ack),
        .lookup_req  (lookup_req),
        .xfer_go     (xfer_go),
        .step        (step),
        .flt_stb     (flt_stb),
        .flt_cls     (flt_cls)
    );

    dmau_fault_log #(.ADDR_W(ADDR_W)) u_flt (
        .clk     (clk),
        .rst_n   (rst_n),
        .flt_stb (flt_stb),
        .flt_cls (flt_cls),
        .addr    (dma_addr),
        .dir     (dma_dir),
        .pie     (par_int_en),
        .ee      (err_en),
        .clr     (stat_clr),
        .gstat   (gen_stat),
        .bs_hi   (bsr_hi),
        .bs_lo   (bsr_lo),
        .irq     (irq7)
    );

    assert_step_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !awin_wr) |=> (dma_addr == $past(dma_addr) + 22'd2)
                               && (dma_cnt == $past(dma_cnt) - 14'd1));

    assert_fault_freezes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_stb && !awin_wr && !cnt_wr) |=> $stable(dma_addr) && $stable(dma_cnt));

endmodule

// File: tb/dma_xfer_regs_tb.sv
module dma_xfer_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        awin_wr = 1'b0;
    logic [14:1] awin_lines = '0;
    logic        cnt_wr = 1'b0;
    logic [15:0] cnt_wdata = '0;
    logic        err_en = 1'b0;
    logic        par_int_en = 1'b0;
    logic        stat_clr = 1'b0;
    logic        map_present = 1'b1;
    logic        map_io = 1'b0;
    logic        map_prot = 1'b0;
    logic        auto_ack = 1'b0;
    logic        xfer_ack;
    logic [21:0] dma_addr;
    logic [13:0] dma_cnt;
    logic        dma_dir, dma_en, irq7, lookup_req, xfer_go;
    logic [15:0] cnt_rd, gen_stat, bsr_hi, bsr_lo;

    int n_chk = 0;
    int n_bad = 0;
    logic [21:0] exp_addr = '0;

    assign xfer_ack = xfer_go & auto_ack;

    always #10 clk = ~clk;

    dma_xfer_regs u_dut (
        .clk(clk), .rst_n(rst_n), .awin_wr(awin_wr), .awin_lines(awin_lines),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .err_en(err_en),
        .par_int_en(par_int_en), .stat_clr(stat_clr), .map_present(map_present),
        .map_io(map_io), .map_prot(map_prot), .xfer_ack(xfer_ack),
        .dma_addr(dma_addr), .dma_cnt(dma_cnt), .dma_dir(dma_dir), .dma_en(dma_en),
        .cnt_rd(cnt_rd), .gen_stat(gen_stat), .bsr_hi(bsr_hi), .bsr_lo(bsr_lo),
        .irq7(irq7), .lookup_req(lookup_req), .xfer_go(xfer_go)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic load_hi(input logic [12:0] f);
        awin_wr = 1'b1; awin_lines = {1'b1, f};
        @(negedge clk);
        awin_wr = 1'b0;
        exp_addr[21:9] = f;
    endtask

    task automatic load_lo(input logic [7:0] f);
        awin_wr = 1'b1; awin_lines = {1'b0, 5'b10101, f};
        @(negedge clk);
        awin_wr = 1'b0;
        exp_addr[8:1] = f;
    endtask

    task automatic load_cnt(input logic [15:0] d);
        cnt_wr = 1'b1; cnt_wdata = d;
        @(negedge clk);
        cnt_wr = 1'b0;
    endtask

    task automatic clear_stat();
        stat_clr = 1'b1;
        @(negedge clk);
        stat_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 addr", dma_addr, 0);
        chk("R1 cnt", dma_cnt, 0);
        chk("R1 dir/en", {dma_dir, dma_en}, 0);
        chk("R1 gen_stat", gen_stat, 16'hFFFF);
        chk("R1 bsr_hi", bsr_hi, 16'hFFFF);
        chk("R1 bsr_lo", bsr_lo, 16'hFFFF);
        chk("R1 irq/req/go", {irq7, lookup_req, xfer_go}, 0);
    endtask

    task automatic t_addr_load();
        load_hi(13'h1555);
        chk("R2 high half", dma_addr, exp_addr);
        load_lo(8'h63);
        chk("R3 low half, lines 13:9 ignored", dma_addr, exp_addr);
        load_hi(13'h0ABC);
        chk("R2 low bits kept", dma_addr, exp_addr);
    endtask

    task automatic t_count_rd();
        load_cnt(16'h4005);
        chk("R4 count", dma_cnt, 14'd6);
        chk("R4 dir/en", {dma_dir, dma_en}, 2'b10);
        chk("R5 read value", cnt_rd, 16'hC006);
        idle(4);
        chk("R7 idle with enable clear", {lookup_req, xfer_go}, 0);
        chk("R4 count held", dma_cnt, 14'd6);
    endtask

    task automatic t_wrap();
        load_cnt(16'hBFFF);
        chk("R4 wrap to zero", dma_cnt, 0);
        chk("R5 read after wrap", cnt_rd, 16'hC000);
        idle(8);
        chk("R6 zero count starts nothing", dma_addr, exp_addr);
    endtask

    task automatic t_run();
        auto_ack = 1'b1;
        load_cnt(16'h8003);
        idle(3);
        chk("R6 first word addr", dma_addr, exp_addr + 22'd2);
        chk("R6 first word count", dma_cnt, 14'd3);
        idle(12);
        exp_addr = exp_addr + 22'd8;
        chk("R6 end addr", dma_addr, exp_addr);
        chk("R6 end count", dma_cnt, 0);
        chk("R6 quiet, enable kept", {dma_en, lookup_req, xfer_go}, 3'b100);
        auto_ack = 1'b0;
    endtask

    task automatic t_stop();
        auto_ack = 1'b0;
        load_cnt(16'h8014);
        idle(3);
        chk("R6 waiting on ack", xfer_go, 1'b1);
        load_cnt(16'h0009);
        auto_ack = 1'b1;
        idle(20);
        chk("R7 count kept", dma_cnt, 14'd10);
        chk("R7 addr kept", dma_addr, exp_addr);
        chk("R7 no requests", {lookup_req, xfer_go}, 0);
        auto_ack = 1'b0;
    endtask

    task automatic t_fault(input string tag, input logic pr, input logic io, input logic pt,
                           input logic dir, input logic pie, input logic ee,
                           input logic [15:0] exp_gs, input logic exp_irq);
        map_present = pr; map_io = io; map_prot = pt;
        par_int_en = pie; err_en = ee; auto_ack = 1'b1;
        load_cnt({1'b1, dir, 14'd4});
        idle(6);
        chk({tag, " R8 gen_stat"}, gen_stat, exp_gs);
        chk({tag, " R9 bsr_hi"}, bsr_hi, 16'h3C00 | {10'd0, exp_addr[21:16]});
        chk({tag, " R9 bsr_lo"}, bsr_lo, exp_addr[15:0]);
        chk({tag, " R10 enable cleared"}, dma_en, 1'b0);
        chk({tag, " R10 count kept"}, dma_cnt, 14'd5);
        chk({tag, " R10 addr kept"}, dma_addr, exp_addr);
        chk({tag, " R11 irq"}, irq7, exp_irq);
        idle(3);
        chk({tag, " R11 irq held"}, irq7, exp_irq);
        clear_stat();
        chk({tag, " R11 cleared"}, {gen_stat, bsr_hi, bsr_lo, 13'd0, irq7, 2'd0}, {48'hFFFF_FFFF_FFFF, 16'd0});
        map_present = 1'b1; map_io = 1'b0; map_prot = 1'b0; auto_ack = 1'b0;
    endtask

    task automatic t_prot_read();
        map_prot = 1'b1; auto_ack = 1'b1; err_en = 1'b1;
        load_cnt(16'hC001);
        idle(10);
        exp_addr = exp_addr + 22'd4;
        chk("R8 protect ignored on read", gen_stat, 16'hFFFF);
        chk("R8 read run completed", dma_addr, exp_addr);
        chk("R8 no irq", irq7, 1'b0);
        map_prot = 1'b0; auto_ack = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_addr_load();
        t_count_rd();
        t_wrap();
        t_run();
        t_stop();
        t_fault("absent wins", 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 16'hAFFF, 1'b1);
        t_fault("io range", 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'hFAFF, 1'b0);
        t_fault("protect", 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'hBBFF, 1'b1);
        t_prot_read();
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule